// File: doc/BRIEF.md
# Section Boundary Metric Store

An iterative trellis decoder can cut a codeword into fixed-length sections of nT stages, where n is 4, 8, 16, 32 or 64 and each stage carries one symbol. The sections are then decoded in parallel. This block supplies the value at which each section's forward or backward recursion starts. When a recursion engine finishes a section, it writes the final state metrics to this store. In the next iteration, the engine that decodes the same section reads those metrics back and starts from them, so it does not have to wait for a neighbouring section.

There are four independent banks: forward and backward metrics for each of the two decoding rounds of an iteration. Each bank holds one word per section boundary. A word contains one signed metric per trellis state. The caller supplies a 0-based iteration counter. On iteration 0 nothing has been stored yet, so in-range reads return all-zero metrics. A read may also ask for a boundary lying a number of sections back along the recursion direction, so the recursion can run over extra stages before it reaches its own section. If that request falls off either end of the codeword, the block returns the known termination vector instead.

Top module: `boundary_metric_store`

## Requirements
- R1: `rd_valid` is high in exactly the cycle after a cycle with `rd_en` high and low otherwise. After reset, `rd_valid` is 0 and `rd_metrics` is all zero.
- R2: A read issued with `iter_idx` = 0 whose target section is in range returns all-zero metrics.
- R3: A read issued with `iter_idx` ≥ 1 and `rd_back` = 0 returns the word most recently written to the same bank and section.
- R4: The bank is selected by the pair (round, direction). A write to one bank never changes what the other three banks return.
- R5: When a read and a write address the same bank and section in the same cycle, the read returns the old word. The new word is returned by later reads.
- R6: A forward read (`rd_beta` = 0) with `rd_back` = K targets section `rd_sec` − K.
- R7: A backward read (`rd_beta` = 1) with `rd_back` = K targets section `rd_sec` + K.
- R8: If the target section lies below 0 or above NSEC−1, the read returns the termination vector on any iteration. In that vector, state 0 is 0 and every other state is the most negative code (MSB 1, other bits 0). State s occupies bits [s·MW +: MW].
- R9: `rd_metrics` keeps its value in every cycle that follows a cycle with `rd_en` low.
- R10: A cycle with `wr_en` low changes no stored word, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_round | input | 1 | Round of the written word |
| wr_beta | input | 1 | 0 = forward metrics, 1 = backward metrics |
| wr_sec | input | SW | Section index written |
| wr_metrics | input | NSTATE·MW | Packed metrics to store |
| rd_en | input | 1 | Read strobe |
| rd_round | input | 1 | Round of the read |
| rd_beta | input | 1 | Direction of the read |
| rd_sec | input | SW | Section whose start value is wanted |
| rd_back | input | KW | Extension distance in sections (0 = none) |
| iter_idx | input | IW | 0-based iteration counter |
| rd_valid | output | 1 | Read data valid |
| rd_metrics | output | NSTATE·MW | Packed start metrics, one cycle after the read |

## Verification
Suppose a bank decode or a section address is wrong. The read that follows the write then returns another section's word, with a mismatch in one cycle. Random traffic across all four banks brings this out within a few iterations. A bad range test or bad offset arithmetic appears as a termination vector where stored data was expected, or the reverse, so reads use random extension distances close to the codeword ends. A fault in read-over-write ordering or in the zero override shows up on the first read in the affected cycle. Directed same-address cycles and first-iteration reads catch it.

// File: rtl/bms_pkg.sv
package bms_pkg;
  localparam int NBANK = 4;

  typedef enum logic [1:0] {
    SRC_MEM  = 2'd0,
    SRC_ZERO = 2'd1,
    SRC_TERM = 2'd2
  } src_e;

  function automatic logic [1:0] bank_of(input logic round, input logic beta);
    return {round, beta};
  endfunction
endpackage

// File: rtl/bms_bank.sv
module bms_bank #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int DW    = 48
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/bms_index.sv
module bms_index
  import bms_pkg::*;
#(
  parameter int NSEC = 16,
  parameter int SW   = 4,
  parameter int KW   = 4,
  parameter int IW   = 3
) (
  input  logic          beta,
  input  logic [SW-1:0] sec,
  input  logic [KW-1:0] back,
  input  logic [IW-1:0] iter,
  output logic [SW-1:0] tgt,
  output src_e          src
);
  function automatic int target_pos(input logic b, input logic [SW-1:0] s,
                                    input logic [KW-1:0] k);
    return b ? int'(s) + int'(k) : int'(s) - int'(k);
  endfunction

  int   pos;
  logic in_range;

  always_comb begin
    pos      = target_pos(beta, sec, back);
    in_range = (pos >= 0) && (pos < NSEC);
    tgt      = in_range ? SW'(pos) : '0;
    if (!in_range)      src = SRC_TERM;
    else if (iter == '0) src = SRC_ZERO;
    else                src = SRC_MEM;
  end
endmodule

// File: rtl/boundary_metric_store.sv
module boundary_metric_store
  import bms_pkg::*;
#(
  parameter int N_SYM   = 64,
  parameter int SEC_LEN = 4,
  parameter int NSTATE  = 8,
  parameter int MW      = 6,
  parameter int N_ITER  = 8,
  parameter int KW      = 4,
  localparam int NSEC   = N_SYM / SEC_LEN,
  localparam int SW     = $clog2(NSEC),
  localparam int IW     = $clog2(N_ITER),
  localparam int VW     = NSTATE * MW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_round,
  input  logic          wr_beta,
  input  logic [SW-1:0] wr_sec,
  input  logic [VW-1:0] wr_metrics,
  input  logic          rd_en,
  input  logic          rd_round,
  input  logic          rd_beta,
  input  logic [SW-1:0] rd_sec,
  input  logic [KW-1:0] rd_back,
  input  logic [IW-1:0] iter_idx,
  output logic          rd_valid,
  output logic [VW-1:0] rd_metrics
);
  function automatic logic [VW-1:0] term_vec();
    logic [VW-1:0] v;
    for (int s = 0; s < NSTATE; s++)
      v[s*MW +: MW] = (s == 0) ? '0 : {1'b1, {(MW-1){1'b0}}};
    return v;
  endfunction

  logic [SW-1:0] rd_tgt;
  src_e          rd_src;
  src_e          src_q;
  logic [1:0]    bank_q;
  logic [1:0]    wr_bank;
  logic [1:0]    rd_bank;
  logic [VW-1:0] bank_rd [NBANK];
  logic [NBANK-1:0] wr_hit;
  logic [NBANK-1:0] rd_hit;

  assign wr_bank = bank_of(wr_round, wr_beta);
  assign rd_bank = bank_of(rd_round, rd_beta);

  bms_index #(.NSEC(NSEC), .SW(SW), .KW(KW), .IW(IW)) u_index (
    .beta (rd_beta),
    .sec  (rd_sec),
    .back (rd_back),
    .iter (iter_idx),
    .tgt  (rd_tgt),
    .src  (rd_src)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign wr_hit[b] = wr_en && (wr_bank == 2'(b));
    assign rd_hit[b] = rd_en && (rd_bank == 2'(b)) && (rd_src == SRC_MEM);
    bms_bank #(.DEPTH(NSEC), .AW(SW), .DW(VW)) u_bank (
      .clk   (clk),
      .we    (wr_hit[b]),
      .waddr (wr_sec),
      .wdata (wr_metrics),
      .re    (rd_hit[b]),
      .raddr (rd_tgt),
      .rdata (bank_rd[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      src_q    <= SRC_ZERO;
      bank_q   <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        src_q  <= rd_src;
        bank_q <= rd_bank;
      end
    end
  end

  always_comb begin
    case (src_q)
      SRC_MEM:  rd_metrics = bank_rd[bank_q];
      SRC_TERM: rd_metrics = term_vec();
      default:  rd_metrics = '0;
    endcase
  end
endmodule

// File: rtl/bms_chk.sv
module bms_chk #(
  parameter int SW = 4,
  parameter int KW = 4,
  parameter int IW = 3,
  parameter int MW = 6,
  parameter int VW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          rd_beta,
  input logic [SW-1:0] rd_sec,
  input logic [KW-1:0] rd_back,
  input logic [IW-1:0] iter_idx,
  input logic          rd_valid,
  input logic [VW-1:0] rd_metrics
);
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  p_first_iter_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && iter_idx == '0 && rd_back == '0) |=> (rd_metrics == '0));

  p_fwd_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_beta && (int'(rd_back) > int'(rd_sec)))
      |=> (rd_metrics[MW-1:0] == '0 && rd_metrics[2*MW-1] && rd_metrics[2*MW-2:MW] == '0));

  p_hold_output_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_metrics));
endmodule

bind boundary_metric_store bms_chk #(.SW(SW), .KW(KW), .IW(IW), .MW(MW), .VW(VW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en      (rd_en),
  .rd_beta    (rd_beta),
  .rd_sec     (rd_sec),
  .rd_back    (rd_back),
  .iter_idx   (iter_idx),
  .rd_valid   (rd_valid),
  .rd_metrics (rd_metrics)
);

// File: tb/boundary_metric_store_tb.sv
`timescale 1ns/1ps
module boundary_metric_store_tb;
  localparam int NSEC = 16;
  localparam int SW = 4, KW = 4, IW = 3, MW = 6, NSTATE = 8;
  localparam int VW = NSTATE * MW;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_round, wr_beta, rd_en, rd_round, rd_beta;
  logic [SW-1:0] wr_sec, rd_sec;
  logic [KW-1:0] rd_back;
  logic [IW-1:0] iter_idx;
  logic [VW-1:0] wr_metrics, rd_metrics;
  logic rd_valid;

  always #2 clk = ~clk;

  boundary_metric_store u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_round(wr_round), .wr_beta(wr_beta),
    .wr_sec(wr_sec), .wr_metrics(wr_metrics), .rd_en(rd_en), .rd_round(rd_round),
    .rd_beta(rd_beta), .rd_sec(rd_sec), .rd_back(rd_back), .iter_idx(iter_idx),
    .rd_valid(rd_valid), .rd_metrics(rd_metrics)
  );

  logic [VW-1:0] model [4][NSEC];
  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act,
                     input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] term_val();
    logic [VW-1:0] v = '0;
    for (int s = 1; s < NSTATE; s++) v[s*MW + MW - 1] = 1'b1;
    return v;
  endfunction

  function automatic int tgt_of(input logic b, input int s, input int k);
    return b ? s + k : s - k;
  endfunction

  function automatic logic [VW-1:0] exp_val(input logic r, input logic b, input int s,
                                            input int k, input int it);
    int t = tgt_of(b, s, k);
    if (t < 0 || t >= NSEC) return term_val();
    if (it == 0) return '0;
    return model[{r, b}][t];
  endfunction

  function automatic string tag_of(input logic b, input int s, input int k, input int it);
    int t = tgt_of(b, s, k);
    if (t < 0 || t >= NSEC) return "R8";
    if (it == 0) return "R2";
    if (k == 0) return "R3";
    return b ? "R7" : "R6";
  endfunction

  task automatic step(input bit we, input bit wr, input bit wb, input int ws,
                      input logic [VW-1:0] wd, input bit re, input bit rr, input bit rb,
                      input int rs, input int rk, input int it, input string ovr);
    logic [VW-1:0] e, prev;
    string tg;
    @(negedge clk);
    wr_en = we; wr_round = wr; wr_beta = wb; wr_sec = SW'(ws); wr_metrics = wd;
    rd_en = re; rd_round = rr; rd_beta = rb; rd_sec = SW'(rs); rd_back = KW'(rk);
    iter_idx = IW'(it);
    e = exp_val(rr, rb, rs, rk, it);
    tg = (ovr != "") ? ovr : tag_of(rb, rs, rk, it);
    prev = rd_metrics;
    @(posedge clk);
    if (we) model[{wr, wb}][ws] = wd;
    #1;
    chk(rd_valid == re, "R1", VW'(rd_valid), VW'(re));
    if (re) chk(rd_metrics === e, tg, rd_metrics, e);
    else    chk(rd_metrics === prev, "R9", rd_metrics, prev);
  endtask

  function automatic logic [VW-1:0] rnd_word();
    logic [63:0] w = {$urandom(), $urandom()};
    return w[VW-1:0];
  endfunction

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    wr_en = 0; wr_round = 0; wr_beta = 0; wr_sec = '0; wr_metrics = '0;
    rd_en = 0; rd_round = 0; rd_beta = 0; rd_sec = '0; rd_back = '0; iter_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rd_valid == 1'b0, "R1", VW'(rd_valid), '0);
    chk(rd_metrics == '0, "R1", rd_metrics, '0);

    // iteration 0: fill all banks, first-iteration reads return zero or termination
    for (int b = 0; b < 4; b++)
      for (int s = 0; s < NSEC; s++)
        step(1, b[1], b[0], s, rnd_word(), 0, 0, 0, 0, 0, 0, "");
    for (int n = 0; n < 40; n++)
      step(0, 0, 0, 0, '0, 1, 1'($urandom()), 1'($urandom()),
           int'($urandom_range(NSEC-1)), int'($urandom_range(3)), 0, "");
    // termination at both ends, R8
    step(0, 0, 0, 0, '0, 1, 0, 0, 1, 2, 3, "R8");
    step(0, 0, 0, 0, '0, 1, 1, 1, NSEC-1, 1, 3, "R8");

    // R10: disabled write carries data; then read it back unchanged
    step(0, 0, 0, 5, {VW{1'b1}}, 0, 0, 0, 0, 0, 1, "R10");
    step(0, 0, 0, 0, '0, 1, 0, 0, 5, 0, 1, "R10");

    // R5: read and write same bank/section in one cycle, then reread
    step(1, 1, 0, 7, rnd_word(), 1, 1, 0, 7, 0, 1, "R5");
    step(0, 0, 0, 0, '0, 1, 1, 0, 7, 0, 1, "R5");

    // R4: write one bank, read the same section in the others
    step(1, 0, 0, 2, rnd_word(), 0, 0, 0, 0, 0, 1, "R4");
    step(0, 0, 0, 0, '0, 1, 0, 1, 2, 0, 1, "R4");
    step(0, 0, 0, 0, '0, 1, 1, 0, 2, 0, 1, "R4");
    step(0, 0, 0, 0, '0, 1, 1, 1, 2, 0, 1, "R4");
    step(0, 0, 0, 0, '0, 1, 0, 0, 2, 0, 1, "R4");

    // directed extension reads R6, R7
    step(0, 0, 0, 0, '0, 1, 0, 0, 9, 3, 2, "R6");
    step(0, 0, 0, 0, '0, 1, 1, 1, 4, 3, 2, "R7");

    // random traffic over later iterations
    for (int it = 1; it < 8; it++)
      for (int n = 0; n < 200; n++)
        step(1'($urandom()), 1'($urandom()), 1'($urandom()),
             int'($urandom_range(NSEC-1)), rnd_word(),
             1'($urandom()), 1'($urandom()), 1'($urandom()),
             int'($urandom_range(NSEC-1)), int'($urandom_range(4)), it, "");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule